// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two gate-enable outputs for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It runs on a fast fixed clock. On each PWM edge it hands conduction from one switch to the other. The gap between the two switches is not a fixed count. It follows two digitized comparator flags: one says the low-side gate has discharged, the other says the switch node has fallen.

On a rising PWM edge the low side is released first. The high side waits until the gate flag is seen, then waits a short further dwell. On a falling PWM edge the high side is released first. The low side waits for the switch-node flag. If that flag never comes, a timeout forces the low side on, which lets the stage sink reverse current. A minimum high-side on-time and a minimum low-side off-time stop very short command pulses from producing gate chatter. An enable input and a supply-good input both force the outputs low. When both come back, the sequencer waits for a fresh PWM edge before it drives anything.

The PWM, enable and both comparator flags pass through a synchronizer of `SYNC_STAGES` flops, two by default. All edge counts below assume the default parameters: `SYNC_STAGES`=2, `HS_DWELL_CYC`=4, `HS_MIN_ON_CYC`=8, `LS_MIN_OFF_CYC`=28, `LS_FORCE_CYC`=35. Edges are counted from the clock interval in which an input changes, and the first rising clock edge after that change is edge 1.

Top module: `deadtime_gate_seq`

## Requirements
- R1: `hi_drive` and `lo_drive` are never both high in the same cycle.
- R2: When `drv_enable` goes low, both outputs are low from the 3rd edge onward. While `drv_enable` stays low, changes on `pwm_cmd` have no effect on either output.
- R3: When `supply_good` is low at a clock edge, both outputs are low after that edge.
- R4: After reset, and again whenever enable and supply-good are both restored, both outputs stay low until the synchronized PWM shows a fresh edge. A level that was already present does not count as an edge.
- R5: A rising PWM edge turns `lo_drive` off on the 3rd edge. `hi_drive` turns on only after the gate flag has been seen high for `HS_DWELL_CYC`+1 consecutive cycles. If the flag was already high, `hi_drive` turns on at the 8th edge after PWM rises. If the flag rises later, `hi_drive` turns on at the 7th edge after the flag rises.
- R6: A falling PWM edge turns `hi_drive` off on the 3rd edge, once the minimum on-time is met. `lo_drive` then waits for the node flag. It turns on at the 3rd edge after the node flag rises, or at the 4th edge after PWM falls if the flag is already high and the minimum off-time is already met.
- R7: If the node flag stays low, `lo_drive` is forced on at the (`LS_FORCE_CYC`+2)-th edge after PWM falls, which is the 37th edge.
- R8: `hi_drive`, once high, stays high for at least `HS_MIN_ON_CYC` cycles even if PWM has already returned low. Loss of enable or supply-good is the only exception.
- R9: `lo_drive`, once low, stays low for at least `LS_MIN_OFF_CYC` cycles. When it is released by a rising PWM edge and reclaimed as early as possible, it turns on again at the 31st edge after that PWM rise.
- R10: If PWM falls before `hi_drive` has turned on, `hi_drive` never turns on for that pulse, and `lo_drive` comes back under the rules of R6 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_cmd | input | 1 | PWM command, asynchronous |
| drv_enable | input | 1 | Enable; low forces both outputs off, asynchronous |
| supply_good | input | 1 | Supply above its start threshold (hysteresis handled outside), synchronous |
| lo_gate_below | input | 1 | Comparator flag: low-side gate is below its threshold |
| node_below | input | 1 | Comparator flag: switch node is below its threshold |
| hi_drive | output | 1 | High-side gate enable |
| lo_drive | output | 1 | Low-side gate enable |

## Verification
A wrong sequencer state shows up at the ports as an edge on `hi_drive` or `lo_drive` that comes in the wrong clock cycle, or that should not have come at all. The synchronizer plus the state register put every reaction a fixed number of edges after its cause. A slip of even one cycle in a dwell, minimum-width or fallback window therefore shows up at the first transition after the window ends. The scoreboard records the exact cycle of every expected output transition. Any mismatch in cycle or value, and any transition it did not expect, is reported when that transition happens.

// File: rtl/dgs_pkg.sv
// Package: shared types for the adaptive dead-time gate sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dgs_pkg;

    // Sequencer states; the outputs are decoded from the next state.
    typedef enum logic [2:0] {
        SEQ_IDLE       = 3'd0,  // both off, waiting for a fresh PWM edge
        SEQ_LO_RELEASE = 3'd1,  // low side dropped, waiting for gate flag
        SEQ_HI_DWELL   = 3'd2,  // gate flag seen, counting extra dwell
        SEQ_HI_ON      = 3'd3,  // high side conducting
        SEQ_NODE_WAIT  = 3'd4,  // high side dropped, waiting for node flag
        SEQ_LO_ON      = 3'd5   // low side conducting
    } seq_state_t;

    // Bit positions inside the synchronizer bundle.
    localparam int SB_PWM   = 0;
    localparam int SB_EN    = 1;
    localparam int SB_GATE  = 2;
    localparam int SB_NODE  = 3;
    localparam int SB_WIDTH = 4;

endpackage

// File: rtl/dgs_sync.sv
// Module: multi-bit, multi-stage synchronizer for asynchronous control inputs.
// What it does: passes each bit through its own chain of STAGES flops.
// Assumes: each bit is an independent level; STAGES >= 2; reset value is 0.
module dgs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the raw level into this bit's flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dgs_span_timer.sv
// Module: saturating interval timer.
// What it does: counts cycles while clr is low. done is high in the
// LIMIT-th cycle after clr was last seen high, and stays high after that.
// A state that leaves on done therefore lasts exactly LIMIT cycles.
// Assumes: LIMIT >= 1.
module dgs_span_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Restart on clr, otherwise count up and hold at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr)           cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/dgs_fsm.sv
// Module: hand-over state machine of the dead-time sequencer.
// What it does: decides which switch may conduct, from the synchronized
// PWM level and its edges, the comparator flags and the timer results.
// Assumes: all inputs are synchronous; the timers' clears come from state_q.
module dgs_fsm
    import dgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,          // enable and supply-good both true
    input  logic       pwm_s,
    input  logic       gate_s,       // low-side gate below threshold
    input  logic       node_s,       // switch node below threshold
    input  logic       dwell_done,
    input  logic       hi_min_done,
    input  logic       lo_off_done,
    input  logic       force_done,
    output seq_state_t state_q,
    output logic       hi_q,
    output logic       lo_q
);

    seq_state_t state_d;
    logic       pwm_prev_q;
    logic       pwm_rise;
    logic       pwm_fall;

    assign pwm_rise = pwm_s & ~pwm_prev_q;
    assign pwm_fall = ~pwm_s & pwm_prev_q;

    // Track the previous PWM level for edge detection, even while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_prev_q <= 1'b0;
        else        pwm_prev_q <= pwm_s;
    end

    // Next-state rules for the hand-over.
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (pwm_rise)      state_d = SEQ_LO_RELEASE;
                    else if (pwm_fall) state_d = SEQ_NODE_WAIT;
                end
                SEQ_LO_RELEASE: begin
                    if (!pwm_s)       state_d = SEQ_NODE_WAIT;
                    else if (gate_s)  state_d = SEQ_HI_DWELL;
                end
                SEQ_HI_DWELL: begin
                    if (!pwm_s)          state_d = SEQ_NODE_WAIT;
                    else if (!gate_s)    state_d = SEQ_LO_RELEASE;
                    else if (dwell_done) state_d = SEQ_HI_ON;
                end
                SEQ_HI_ON: begin
                    if (!pwm_s && hi_min_done) state_d = SEQ_NODE_WAIT;
                end
                SEQ_NODE_WAIT: begin
                    if (pwm_s)
                        state_d = SEQ_LO_RELEASE;
                    else if (lo_off_done && (node_s || force_done))
                        state_d = SEQ_LO_ON;
                end
                SEQ_LO_ON: begin
                    if (pwm_s) state_d = SEQ_LO_RELEASE;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Register the state and the glitch-free output decode together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_q    <= (state_d == SEQ_HI_ON);
            lo_q    <= (state_d == SEQ_LO_ON);
        end
    end

endmodule

// File: rtl/deadtime_gate_seq.sv
// Module: adaptive dead-time gate sequencer (top).
// What it does: synchronizes the asynchronous inputs, runs four interval
// timers (dwell, high-side minimum on, low-side minimum off, low-side
// fallback), and drives the hand-over state machine.
// Assumes: supply_good is already synchronous to clk; comparator flags are
// active high when the sensed voltage is below its threshold.
module deadtime_gate_seq
    import dgs_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int HS_DWELL_CYC   = 4,
    parameter int HS_MIN_ON_CYC  = 8,
    parameter int LS_MIN_OFF_CYC = 28,
    parameter int LS_FORCE_CYC   = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic drv_enable,
    input  logic supply_good,
    input  logic lo_gate_below,
    input  logic node_below,
    output logic hi_drive,
    output logic lo_drive
);

    logic [SB_WIDTH-1:0] raw_bus;
    logic [SB_WIDTH-1:0] sync_bus;
    logic                pwm_s;
    logic                en_s;
    logic                lsg_s;
    logic                swn_s;
    logic                run_ok;
    seq_state_t          state_q;
    logic                dwell_done;
    logic                hi_min_done;
    logic                lo_off_done;
    logic                force_done;

    assign raw_bus[SB_PWM]  = pwm_cmd;
    assign raw_bus[SB_EN]   = drv_enable;
    assign raw_bus[SB_GATE] = lo_gate_below;
    assign raw_bus[SB_NODE] = node_below;

    dgs_sync #(
        .WIDTH  (SB_WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign pwm_s  = sync_bus[SB_PWM];
    assign en_s   = sync_bus[SB_EN];
    assign lsg_s  = sync_bus[SB_GATE];
    assign swn_s  = sync_bus[SB_NODE];
    assign run_ok = en_s & supply_good;

    // Extra dwell after the gate flag, restarted outside the dwell state.
    dgs_span_timer #(.LIMIT(HS_DWELL_CYC)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SEQ_HI_DWELL),
        .done  (dwell_done)
    );

    // High-side minimum on-time, measured from entry into the on state.
    dgs_span_timer #(.LIMIT(HS_MIN_ON_CYC)) u_hi_min (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SEQ_HI_ON),
        .done  (hi_min_done)
    );

    // Low-side minimum off-time, measured from leaving the on state.
    dgs_span_timer #(.LIMIT(LS_MIN_OFF_CYC)) u_lo_off (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == SEQ_LO_ON),
        .done  (lo_off_done)
    );

    // Fallback window, measured from the synchronized PWM falling edge.
    dgs_span_timer #(.LIMIT(LS_FORCE_CYC)) u_force (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwm_s),
        .done  (force_done)
    );

    dgs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_ok),
        .pwm_s       (pwm_s),
        .gate_s      (lsg_s),
        .node_s      (swn_s),
        .dwell_done  (dwell_done),
        .hi_min_done (hi_min_done),
        .lo_off_done (lo_off_done),
        .force_done  (force_done),
        .state_q     (state_q),
        .hi_q        (hi_drive),
        .lo_q        (lo_drive)
    );

endmodule

// File: rtl/dgs_checker.sv
// Module: property checker for the dead-time sequencer, bound to the top.
// What it does: keeps its own run-length counters of the outputs and of
// the synchronized PWM low time, and checks the timing rules against them.
// Assumes: bound into deadtime_gate_seq, with access to its synchronized signals.
module dgs_checker #(
    parameter int HS_MIN_ON  = 8,
    parameter int LS_MIN_OFF = 28,
    parameter int LS_FORCE   = 35
) (
    input logic clk,
    input logic rst_n,
    input logic hi_drive,
    input logic lo_drive,
    input logic supply_good,
    input logic run_ok,
    input logic pwm_s,
    input logic lsg_s,
    input logic swn_s
);

    localparam int HI_W = $clog2(HS_MIN_ON + 1);
    localparam int LO_W = $clog2(LS_MIN_OFF + 1);
    localparam int FB_W = $clog2(LS_FORCE + 1);

    logic [HI_W-1:0] hi_run_q;
    logic [LO_W-1:0] lo_gap_q;
    logic [FB_W-1:0] pwm_low_q;

    // Count consecutive high cycles of the high-side output.
    always_ff @(posedge clk) begin
        if (!rst_n || !hi_drive)           hi_run_q <= '0;
        else if (hi_run_q != HI_W'(HS_MIN_ON)) hi_run_q <= hi_run_q + 1'b1;
    end

    // Count consecutive low cycles of the low-side output.
    always_ff @(posedge clk) begin
        if (!rst_n || lo_drive)               lo_gap_q <= '0;
        else if (lo_gap_q != LO_W'(LS_MIN_OFF)) lo_gap_q <= lo_gap_q + 1'b1;
    end

    // Count cycles since the synchronized PWM went low.
    always_ff @(posedge clk) begin
        if (!rst_n || pwm_s)                 pwm_low_q <= '0;
        else if (pwm_low_q != FB_W'(LS_FORCE)) pwm_low_q <= pwm_low_q + 1'b1;
    end

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_drive && lo_drive));

    assert_supply_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good |=> (!hi_drive && !lo_drive));

    assert_hi_after_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_drive) |-> ($past(lsg_s) && !$past(lo_drive)));

    // R6 and R7: the low side starts only on the node flag or the fallback.
    assert_lo_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_drive) |-> ($past(swn_s) || (int'($past(pwm_low_q)) >= LS_FORCE - 1)));

    assert_hi_min_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hi_drive) && $past(run_ok)) |-> (int'($past(hi_run_q)) >= HS_MIN_ON - 1));

    assert_lo_min_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_drive) |-> (int'($past(lo_gap_q)) >= LS_MIN_OFF - 1));

endmodule

bind deadtime_gate_seq dgs_checker #(
    .HS_MIN_ON  (HS_MIN_ON_CYC),
    .LS_MIN_OFF (LS_MIN_OFF_CYC),
    .LS_FORCE   (LS_FORCE_CYC)
) u_dgs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_drive    (hi_drive),
    .lo_drive    (lo_drive),
    .supply_good (supply_good),
    .run_ok      (run_ok),
    .pwm_s       (pwm_s),
    .lsg_s       (lsg_s),
    .swn_s       (swn_s)
);

// File: tb/tb_deadtime_gate_seq.sv
// Bench: scoreboard for the dead-time sequencer with default parameters.
// The driver drives inputs on falling clock edges and pushes the expected
// output transitions (cycle, values) into a queue. The monitor pops one
// entry on every output change it sees.
module tb_deadtime_gate_seq;

    typedef struct {
        int    cyc;
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;

    logic clk;
    logic rst_n;
    logic pwm_cmd;
    logic drv_enable;
    logic supply_good;
    logic lo_gate_below;
    logic node_below;
    logic hi_drive;
    logic lo_drive;

    int   cyc;
    int   checks;
    int   errors;
    bit   overlap_seen;
    bit   finished;
    exp_t sb_q[$];
    exp_t got_e;
    logic [1:0] prev_out;

    deadtime_gate_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_cmd       (pwm_cmd),
        .drv_enable    (drv_enable),
        .supply_good   (supply_good),
        .lo_gate_below (lo_gate_below),
        .node_below    (node_below),
        .hi_drive      (hi_drive),
        .lo_drive      (lo_drive)
    );

    // 125 MHz clock.
    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Cycle counter: number of rising edges seen so far.
    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(int delta, logic h, logic l, string tag);
        exp_t e;
        e.cyc = cyc + delta;
        e.hi  = h;
        e.lo  = l;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic check_now(logic h, logic l, string tag);
        checks++;
        if (hi_drive !== h || lo_drive !== l) begin
            errors++;
            $display("FAIL %s: hi=%0b lo=%0b, expected hi=%0b lo=%0b", tag, hi_drive, lo_drive, h, l);
        end
    endtask

    // Monitor: match every output change against the scoreboard.
    initial prev_out = 2'b00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hi_drive && lo_drive) overlap_seen = 1'b1;
            if ({hi_drive, lo_drive} != prev_out) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4/R5/R6 unexpected change at cycle %0d: hi=%0b lo=%0b, expected no change from hi=%0b lo=%0b",
                             cyc, hi_drive, lo_drive, prev_out[1], prev_out[0]);
                end else begin
                    got_e = sb_q.pop_front();
                    if (got_e.cyc != cyc || got_e.hi !== hi_drive || got_e.lo !== lo_drive) begin
                        errors++;
                        $display("FAIL %s: cycle %0d hi=%0b lo=%0b, expected cycle %0d hi=%0b lo=%0b",
                                 got_e.tag, cyc, hi_drive, lo_drive, got_e.cyc, got_e.hi, got_e.lo);
                    end
                end
                prev_out = {hi_drive, lo_drive};
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        finished = 1'b0;
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks        = 0;
        errors        = 0;
        overlap_seen  = 1'b0;
        rst_n         = 1'b0;
        pwm_cmd       = 1'b0;
        drv_enable    = 1'b1;
        supply_good   = 1'b1;
        lo_gate_below = 1'b0;
        node_below    = 1'b0;
        step(5);
        rst_n = 1'b1;
        check_now(1'b0, 1'b0, "R4 reset state");
        step(10);
        check_now(1'b0, 1'b0, "R4 idle without PWM edge");

        // R5: gate flag arrives late, then R6: node flag releases the low side.
        pwm_cmd = 1'b1;
        step(5);
        lo_gate_below = 1'b1;
        expect_at(7, 1'b1, 1'b0, "R5 high side after late gate flag");
        step(25);
        pwm_cmd = 1'b0;
        lo_gate_below = 1'b0;
        expect_at(3, 1'b0, 1'b0, "R6 high side off on falling PWM");
        step(6);
        node_below = 1'b1;
        expect_at(3, 1'b0, 1'b1, "R6 low side on after node flag");
        step(20);

        // R8 short command pulse keeps high side for minimum on-time; R9 then holds the low side off.
        lo_gate_below = 1'b1;
        pwm_cmd = 1'b1;
        expect_at(3, 1'b0, 1'b0, "R5 low side off on rising PWM");
        expect_at(8, 1'b1, 1'b0, "R5 high side after dwell with flag high");
        step(6);
        pwm_cmd = 1'b0;
        expect_at(10, 1'b0, 1'b0, "R8 high side held for minimum on-time");
        expect_at(25, 1'b0, 1'b1, "R9 low side held off for minimum off-time");
        step(40);

        // R7: the node flag never rises, so the fallback turns the low side on.
        node_below = 1'b0;
        pwm_cmd = 1'b1;
        expect_at(3, 1'b0, 1'b0, "R5 low side off on rising PWM");
        expect_at(8, 1'b1, 1'b0, "R5 high side on");
        step(20);
        pwm_cmd = 1'b0;
        expect_at(3, 1'b0, 1'b0, "R6 high side off");
        expect_at(37, 1'b0, 1'b1, "R7 forced low side after timeout");
        step(45);

        // R10: the pulse ends before the gate flag appears, so the high side never turns on.
        lo_gate_below = 1'b0;
        node_below = 1'b1;
        pwm_cmd = 1'b1;
        expect_at(3, 1'b0, 1'b0, "R10 low side released by short pulse");
        expect_at(31, 1'b0, 1'b1, "R10 low side back after minimum off-time");
        step(5);
        pwm_cmd = 1'b0;
        step(40);

        // R2: enable drop; R4: no restart without a fresh edge.
        lo_gate_below = 1'b1;
        pwm_cmd = 1'b1;
        expect_at(3, 1'b0, 1'b0, "R5 low side off on rising PWM");
        expect_at(8, 1'b1, 1'b0, "R5 high side on");
        step(15);
        drv_enable = 1'b0;
        expect_at(3, 1'b0, 1'b0, "R2 enable low forces outputs off");
        step(5);
        pwm_cmd = 1'b0;
        step(5);
        check_now(1'b0, 1'b0, "R2 PWM ignored while disabled");
        drv_enable = 1'b1;
        step(50);
        check_now(1'b0, 1'b0, "R4 re-enable waits for fresh edge");
        pwm_cmd = 1'b1;
        expect_at(8, 1'b1, 1'b0, "R4 restart on fresh rising edge");
        step(20);

        // R3: supply-good drop, then R4 steady PWM high does not restart.
        supply_good = 1'b0;
        expect_at(1, 1'b0, 1'b0, "R3 supply low forces outputs off");
        step(6);
        supply_good = 1'b1;
        step(20);
        check_now(1'b0, 1'b0, "R4 supply restore waits for fresh edge");
        pwm_cmd = 1'b0;
        expect_at(4, 1'b0, 1'b1, "R6 falling edge from idle with node flag high");
        step(20);

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R5/R6/R7 pending transitions: %0d left, expected 0", sb_q.size());
        end
        checks++;
        if (overlap_seen) begin
            errors++;
            $display("FAIL R1 overlap: both outputs high seen=1, expected 0");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule